// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execution stage of a small RISC pipeline. Each cycle it takes a 4-bit operation code, a first operand, and a second operand that the shifter stage has already prepared. It also takes the shifter's carry-out, the current condition flags and a control bit that allows the flags to be updated. From these it produces a 32-bit result, a strobe that tells the register file whether to write that result, and the next value of the four condition flags. All three outputs are registered on the rising clock edge.

One shared adder handles all eight arithmetic operations. Subtraction and reverse subtraction are built by swapping and inverting operands, and carry on subtraction uses the "no borrow" sense. Compare and test operations update only the flags and never request a register write. Logical and move operations take their carry from the shifter and leave the overflow flag as it was.

Top module: `dp_alu`

## Requirements
- R1: Codes ADD=4, SUB=2 and RSB=3 return first+second, first−second and second−first modulo 2^32, with the write strobe high (for example, RSB with first 0x77 and second 0 gives 0xFFFFFF89).
- R2: ADC=5 returns first+second+C, SBC=6 returns first−second−(1−C), and RSC=7 returns second−first−(1−C), where C is flag bit 1 of the flags input. The write strobe is high.
- R3: AND=0, EOR=1, ORR=12, BIC=14 (first AND NOT second), MOV=13 (second) and MVN=15 (NOT second) return their bitwise results with the write strobe high.
- R4: TST=8, TEQ=9, CMP=10 and CMN=11 drive the write strobe low and set the flags from first AND second, first XOR second, first−second and first+second respectively.
- R5: When the set-flags bit is 0, the registered flags equal the flags input of that cycle, whatever the operation.
- R6: Flags are packed as bit3=N, bit2=Z, bit1=C, bit0=V. When flags are updated, N is bit 31 of the operation value and Z is 1 exactly when that value is zero.
- R7: When flags are updated by an arithmetic or compare operation, C is the unsigned carry-out of the adder. For subtractions this means C=1 when there is no borrow (1−1 gives Z=1, C=1).
- R8: When flags are updated by a logical, move or test operation, C takes the shifter carry input and V keeps its input value.
- R9: When flags are updated by an arithmetic or compare operation, V is 1 exactly when the true signed result lies outside the 32-bit two's-complement range (0x7FFFFFFF+1 and 0x80000000−1 both set V).
- R10: Outputs appear one clock after their inputs. A synchronous active-high reset clears the result, the write strobe and the flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| sh_carry_i | input | 1 | Carry-out from the shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| set_flags_i | input | 1 | Allow flag update |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered result-write strobe |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
The assertions watch every cycle for the properties that depend only on the operation class. Compare and test codes never raise the write strobe. Cleared set-flags passes the flags through unchanged. For written results, N and Z agree with the registered result. Logical-class operations take C from the shifter and keep V. The numeric correctness of each sum, difference and bitwise value can only be shown by the bench scenarios. The same holds for the no-borrow carry and the signed-overflow detection, including the two boundary overflows. The bench compares these against an exact wide-integer model.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_XOR  = 3'd1,
    LG_OR   = 3'd2,
    LG_PASS = 3'd3,
    LG_BIC  = 3'd4,
    LG_NOT  = 3'd5
  } lg_op_e;

  typedef struct packed {
    logic     arith;
    logic     wr;
    logic     swap;
    logic     inv_b;
    cin_sel_e cin;
    lg_op_e   lop;
  } alu_ctrl_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/dp_alu_dec.sv
module dp_alu_dec
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o       = '0;
    ctrl_o.wr    = 1'b1;
    ctrl_o.cin   = CIN_ZERO;
    ctrl_o.lop   = LG_PASS;
    unique case (alu_op_e'(op_i))
      OP_AND: ctrl_o.lop = LG_AND;
      OP_EOR: ctrl_o.lop = LG_XOR;
      OP_ORR: ctrl_o.lop = LG_OR;
      OP_MOV: ctrl_o.lop = LG_PASS;
      OP_BIC: ctrl_o.lop = LG_BIC;
      OP_MVN: ctrl_o.lop = LG_NOT;
      OP_TST: begin ctrl_o.lop = LG_AND; ctrl_o.wr = 1'b0; end
      OP_TEQ: begin ctrl_o.lop = LG_XOR; ctrl_o.wr = 1'b0; end
      OP_ADD: ctrl_o.arith = 1'b1;
      OP_ADC: begin ctrl_o.arith = 1'b1; ctrl_o.cin = CIN_FLAG; end
      OP_SUB: begin ctrl_o.arith = 1'b1; ctrl_o.inv_b = 1'b1; ctrl_o.cin = CIN_ONE; end
      OP_SBC: begin ctrl_o.arith = 1'b1; ctrl_o.inv_b = 1'b1; ctrl_o.cin = CIN_FLAG; end
      OP_RSB: begin
        ctrl_o.arith = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.inv_b = 1'b1; ctrl_o.cin = CIN_ONE;
      end
      OP_RSC: begin
        ctrl_o.arith = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.inv_b = 1'b1; ctrl_o.cin = CIN_FLAG;
      end
      OP_CMP: begin
        ctrl_o.arith = 1'b1; ctrl_o.inv_b = 1'b1; ctrl_o.cin = CIN_ONE; ctrl_o.wr = 1'b0;
      end
      OP_CMN: begin ctrl_o.arith = 1'b1; ctrl_o.wr = 1'b0; end
      default: ctrl_o.lop = LG_PASS;
    endcase
  end

endmodule

// File: rtl/dp_alu_add.sv
module dp_alu_add
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         swap_i,
  input  logic         inv_b_i,
  input  cin_sel_e     cin_sel_i,
  input  logic         cflag_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   full;
  logic         c_into_msb;

  always_comb begin
    x = swap_i ? b_i : a_i;
    y = swap_i ? a_i : b_i;
    if (inv_b_i) y = ~y;
    unique case (cin_sel_i)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = cflag_i;
      default:  cin = 1'b0;
    endcase
    full       = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum_o      = full[W-1:0];
    cout_o     = full[W];
    c_into_msb = full[W-1] ^ x[W-1] ^ y[W-1];
    ovf_o      = c_into_msb ^ full[W];
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lg_op_e       lop_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (lop_i)
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_BIC:  res_o = a_i & ~b_i;
      LG_NOT:  res_o = ~b_i;
      default: res_o = b_i;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sh_carry_i,
  input  logic [3:0]   flags_i,
  input  logic         set_flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);

  localparam int MSB = W - 1;

  alu_ctrl_t    ctrl;
  logic [W-1:0] sum, lres, value;
  logic         cout, ovf;
  logic [3:0]   next_flags;

  dp_alu_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  dp_alu_add #(.W(W)) u_add (
    .a_i       (opa_i),
    .b_i       (opb_i),
    .swap_i    (ctrl.swap),
    .inv_b_i   (ctrl.inv_b),
    .cin_sel_i (ctrl.cin),
    .cflag_i   (flags_i[FLAG_C]),
    .sum_o     (sum),
    .cout_o    (cout),
    .ovf_o     (ovf)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .lop_i (ctrl.lop),
    .res_o (lres)
  );

  always_comb begin
    value = ctrl.arith ? sum : lres;
    if (set_flags_i) begin
      next_flags[FLAG_N] = value[MSB];
      next_flags[FLAG_Z] = (value == '0);
      next_flags[FLAG_C] = ctrl.arith ? cout : sh_carry_i;
      next_flags[FLAG_V] = ctrl.arith ? ovf : flags_i[FLAG_V];
    end else begin
      next_flags = flags_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= value;
      wr_en_o  <= ctrl.wr;
      flags_o  <= next_flags;
    end
  end

  // R4: compare/test codes (binary 10xx) never request a write
  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i[3:2] == 2'b10) |=> !wr_en_o);

  // R5: flags pass through when updating is not enabled
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !set_flags_i |=> (flags_o == $past(flags_i)));

  // R6: Z and N agree with a written result
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (set_flags_i && op_i[3:2] != 2'b10) |=> (flags_o[FLAG_Z] == (result_o == '0)));
  p_neg_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (set_flags_i && op_i[3:2] != 2'b10) |=> (flags_o[FLAG_N] == result_o[MSB]));

  // R8: logical-class operations take C from the shifter and keep V
  p_logic_cv_r8: assert property (@(posedge clk) disable iff (rst)
    (set_flags_i && (op_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
    |=> (flags_o[FLAG_C] == $past(sh_carry_i) && flags_o[FLAG_V] == $past(flags_i[FLAG_V])));

  // R10: reset clears everything
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !wr_en_o && flags_o == '0));

endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        sh_carry_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        set_flags_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dp_alu dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .sh_carry_i(sh_carry_i), .flags_i(flags_i), .set_flags_i(set_flags_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd2, 4'd3, 4'd4:         return "R1";
      4'd5, 4'd6, 4'd7:         return "R2";
      4'd8, 4'd9, 4'd10, 4'd11: return "R4";
      default:                  return "R3";
    endcase
  endfunction

  function automatic bit is_arith(input logic [3:0] op);
    return (op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});
  endfunction

  // reference model: exact wide integers, no shared logic with the design
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic shc, input logic [3:0] fl, input logic sf,
                       output logic [31:0] res, output logic wr, output logic [3:0] nf);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint c  = longint'(fl[1]);
    longint sx = 0, ux = 0;
    logic cc = 1'b0;
    wr = !(op inside {4'd8, 4'd9, 4'd10, 4'd11});
    case (op)
      4'd0, 4'd8: res = a & b;
      4'd1, 4'd9: res = a ^ b;
      4'd12:      res = a | b;
      4'd13:      res = b;
      4'd14:      res = a & ~b;
      4'd15:      res = ~b;
      4'd4, 4'd11: begin sx = sa + sb; ux = ua + ub; cc = (ux >= 64'h1_0000_0000); end
      4'd5:        begin sx = sa + sb + c; ux = ua + ub + c; cc = (ux >= 64'h1_0000_0000); end
      4'd2, 4'd10: begin sx = sa - sb; ux = ua - ub; cc = (ua >= ub); end
      4'd6:        begin sx = sa - sb - (1 - c); ux = ua - ub - (1 - c); cc = (ua >= ub + (1 - c)); end
      4'd3:        begin sx = sb - sa; ux = ub - ua; cc = (ub >= ua); end
      default:     begin sx = sb - sa - (1 - c); ux = ub - ua - (1 - c); cc = (ub >= ua + (1 - c)); end
    endcase
    if (is_arith(op)) res = ux[31:0];
    if (!sf) nf = fl;
    else begin
      nf[3] = res[31];
      nf[2] = (res == 32'd0);
      nf[1] = is_arith(op) ? cc : shc;
      nf[0] = is_arith(op) ? (sx > 64'sd2147483647 || sx < -64'sd2147483648) : fl[0];
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic shc, input logic [3:0] fl, input logic sf);
    logic [31:0] er;
    logic ew;
    logic [3:0] ef;
    model(op, a, b, shc, fl, sf, er, ew, ef);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; sh_carry_i = shc; flags_i = fl; set_flags_i = sf;
    @(negedge clk);  // one register stage: R10 latency
    checks++;
    if (ew && result_o !== er) begin
      errors++;
      $display("FAIL %s op=%0d result actual=%h expected=%h", res_tag(op), op, result_o, er);
    end
    checks++;
    if (wr_en_o !== ew) begin
      errors++;
      $display("FAIL %s op=%0d write actual=%b expected=%b", ew ? res_tag(op) : "R4", op, wr_en_o, ew);
    end
    checks++;
    if (flags_o !== ef) begin
      errors++;
      $display("FAIL %s op=%0d flags actual=%b expected=%b",
               !sf ? "R5" : (is_arith(op) ? "R6 R7 R9" : "R6 R8"), op, flags_o, ef);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (result_o !== 32'd0 || wr_en_o !== 1'b0 || flags_o !== 4'd0) begin
      errors++;
      $display("FAIL R10 reset actual=%h/%b/%b expected=0/0/0", result_o, wr_en_o, flags_o);
    end
    rst = 1'b0;

    // directed corner cases
    run_op(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000, 1'b1);        // R9 positive overflow
    run_op(4'd2, 32'h8000_0000, 32'h1, 1'b0, 4'b0000, 1'b1);        // R9 negative overflow, R7
    run_op(4'd3, 32'h77, 32'h0, 1'b0, 4'b0000, 1'b1);               // R1 reverse subtract
    run_op(4'd2, 32'h1, 32'h1, 1'b0, 4'b0000, 1'b1);                // R7 Z=1 C=1
    run_op(4'd10, 32'd4, 32'd4, 1'b0, 4'b0000, 1'b1);               // R4 compare equal
    run_op(4'd13, 32'h0000_0008, 32'h0000_0008, 1'b1, 4'b0001, 1'b1); // R8 shifter carry, V kept
    run_op(4'd5, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010, 1'b1);        // R2 carry-in ripple
    run_op(4'd6, 32'h5, 32'h5, 1'b0, 4'b0000, 1'b1);                // R2 borrow-in
    run_op(4'd7, 32'h1, 32'h1, 1'b0, 4'b0010, 1'b1);                // R2 reverse with carry
    run_op(4'd14, 32'hF, 32'h5, 1'b0, 4'b0000, 1'b1);               // R3 bit clear
    run_op(4'd12, 32'h0204_0608, 32'h1030_5070, 1'b0, 4'b0000, 1'b0); // R3, R5
    run_op(4'd11, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b1111, 1'b0); // R5 hold with compare
    run_op(4'd9, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0, 4'b0011, 1'b1);  // R4 R8 test-equal

    // constrained random: every opcode, mixed operand styles
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [3:0] op;
      op = 4'(i % 16);
      a = $urandom();
      b = $urandom();
      case ($urandom_range(0, 3))
        0: a = {a[31], 31'(0)} | 32'($urandom_range(0, 3));
        1: b = a;
        default: ;
      endcase
      run_op(op, a, b, 1'($urandom()), 4'($urandom()), ($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule